// File: doc/BRIEF.md
# Multi-cycle RISC processor core

This block is a small processor that runs a subset of a 32-bit load/store instruction set without pipelining. Each instruction moves through a sequence of steps under a state machine: fetch, decode with register read, execute, memory access and, for loads, write-back. Intermediate values are held in internal registers: the program counter, the instruction, the incremented PC, two operand latches, the ALU result and the loaded word. Because the sequence stops early where it can, an instruction takes 3, 4 or 5 clock cycles depending on its class.

The core holds a 32-entry register file and two word-addressed memories, one for instructions and one for data. A loader port shared by both memories lets the environment fill them while reset is held and read either one back. A one-cycle retire pulse marks the last cycle of each instruction, so the length of every instruction can be measured from outside.

Top module: `mc_core`

## Requirements
- R1: While `rst` is high the PC reads 0 and `retire_o` is low. After `rst` falls, the first fetch takes the instruction word at address 0.
- R2: Fetch loads the instruction at the PC and forms PC+4. Every instruction other than a taken branch leaves the PC at the old PC+4 by the cycle after it retires.
- R3: Opcode 0x00 with funct 0x20/0x22/0x24/0x25 (add/sub/and/or) writes rs op rt to register rd. Field positions: rs is bits 25:21, rt is bits 20:16, rd is bits 15:11. The instruction takes 4 cycles.
- R4: Opcode 0x08 (add-immediate) writes rs plus the sign-extended bits 15:0 to register rt and takes 4 cycles.
- R5: Opcode 0x23 (load word) reads the data word at byte address rs + sext(imm), writes it to rt and takes 5 cycles.
- R6: Opcode 0x2B (store word) writes rt to the data word at byte address rs + sext(imm) and takes 4 cycles.
- R7: Opcode 0x04 (branch if rs equals rt) takes 3 cycles. When the operands are equal, the next PC is PC+4+(sext(imm)<<2), which works for negative offsets too. Otherwise the next PC is PC+4.
- R8: Register 0 always reads as zero. Writes to it have no effect.
- R9: Any other opcode, and opcode 0x00 with any other funct, changes no register and no memory word, and takes 4 cycles.
- R10: `retire_o` is high for exactly one cycle, the last cycle of each instruction.
- R11: Memory word index = byte address bits [MAW+1:2]. With `imem_ld_we` or `dmem_ld_we` high, a clock edge writes `ld_data` at `ld_addr` into that memory. The `*_peek` outputs show the word at `ld_addr` one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_addr | input | MAW | Word index for loader writes and peeks |
| ld_data | input | 32 | Loader write data |
| imem_ld_we | input | 1 | Write ld_data into instruction memory |
| dmem_ld_we | input | 1 | Write ld_data into data memory |
| imem_peek | output | 32 | Registered instruction-memory word at ld_addr |
| dmem_peek | output | 32 | Registered data-memory word at ld_addr |
| pc_o | output | 32 | Current program counter |
| retire_o | output | 1 | High in the final cycle of each instruction |

## Verification
The four register ALU operations are swept over every ordered pair from a six-value operand set that includes zero, all-ones and both signed extremes. This separates add from sub, carries from wraparound, and and from or. Add-immediate is tried with signed immediates at both 16-bit limits, which shows whether sign extension is done. Branches are tried with equal and unequal operand pairs and with a self-targeting negative offset, which tells taken from not-taken and checks the offset arithmetic. Directed programs cover negative load offsets, writes to register zero and undefined encodings, and each checks the per-instruction cycle count as well as the data.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB} step_t;
  typedef enum logic [2:0] {K_RALU, K_ADDI, K_LOAD, K_STORE, K_BRANCH, K_NOP} kind_t;
  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} aluop_t;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;
  localparam logic [5:0] FN_AND   = 6'h24;
  localparam logic [5:0] FN_OR    = 6'h25;
endpackage

// File: rtl/mc_ram.sv
module mc_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             core_we,
  input  logic [AW-1:0]    core_addr,
  input  logic [WIDTH-1:0] core_wdata,
  output logic [WIDTH-1:0] core_rdata,
  input  logic             ld_we,
  input  logic [AW-1:0]    ld_addr,
  input  logic [WIDTH-1:0] ld_wdata,
  output logic [WIDTH-1:0] ld_rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (core_we)
      mem[core_addr] <= core_wdata;
    else if (ld_we)
      mem[ld_addr] <= ld_wdata;
    ld_rdata <= mem[ld_addr];
  end

  assign core_rdata = mem[core_addr];
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int WIDTH = 32,
  parameter int COUNT = 32,
  localparam int AW = $clog2(COUNT)
) (
  input  logic             clk,
  input  logic [AW-1:0]    ra1,
  input  logic [AW-1:0]    ra2,
  output logic [WIDTH-1:0] rd1,
  output logic [WIDTH-1:0] rd2,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd
);
  logic [WIDTH-1:0] regs [COUNT];

  always_ff @(posedge clk) begin
    if (we && wa != '0)
      regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_decode.sv
module mc_decode
  import mc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output kind_t      kind,
  output aluop_t     rop
);
  always_comb begin
    kind = K_NOP;
    rop  = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        case (funct)
          FN_ADD: begin kind = K_RALU; rop = ALU_ADD; end
          FN_SUB: begin kind = K_RALU; rop = ALU_SUB; end
          FN_AND: begin kind = K_RALU; rop = ALU_AND; end
          FN_OR:  begin kind = K_RALU; rop = ALU_OR;  end
          default: kind = K_NOP;
        endcase
      end
      OP_ADDI: kind = K_ADDI;
      OP_LW:   kind = K_LOAD;
      OP_SW:   kind = K_STORE;
      OP_BEQ:  kind = K_BRANCH;
      default: kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluop_t           op,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] z
);
  always_comb begin
    case (op)
      ALU_SUB: z = x - y;
      ALU_AND: z = x & y;
      ALU_OR:  z = x | y;
      default: z = x + y;
    endcase
  end
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int MAW = $clog2(MEM_WORDS),
  localparam int XW = 32,
  localparam int NREG = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [MAW-1:0] ld_addr,
  input  logic [XW-1:0]  ld_data,
  input  logic           imem_ld_we,
  input  logic           dmem_ld_we,
  output logic [XW-1:0]  imem_peek,
  output logic [XW-1:0]  dmem_peek,
  output logic [XW-1:0]  pc_o,
  output logic           retire_o
);
  step_t          step_q;
  logic [XW-1:0]  pc_q, npc_q, ir_q, a_q, b_q, tgt_q, alu_q, mdr_q;
  logic [XW-1:0]  imem_rd, dmem_rd, rs_val, rt_val, alu_y, imm_sx, alu_in_b, rf_wd;
  logic [4:0]     rf_wa;
  logic           rf_we, dmem_we;
  kind_t          kind;
  aluop_t         rop, alu_op;

  assign imm_sx = {{(XW-16){ir_q[15]}}, ir_q[15:0]};

  mc_ram #(.WIDTH(XW), .DEPTH(MEM_WORDS)) i_imem (
    .clk(clk), .core_we(1'b0), .core_addr(pc_q[MAW+1:2]), .core_wdata('0),
    .core_rdata(imem_rd), .ld_we(imem_ld_we), .ld_addr(ld_addr),
    .ld_wdata(ld_data), .ld_rdata(imem_peek));

  mc_ram #(.WIDTH(XW), .DEPTH(MEM_WORDS)) i_dmem (
    .clk(clk), .core_we(dmem_we), .core_addr(alu_q[MAW+1:2]), .core_wdata(b_q),
    .core_rdata(dmem_rd), .ld_we(dmem_ld_we), .ld_addr(ld_addr),
    .ld_wdata(ld_data), .ld_rdata(dmem_peek));

  mc_decode i_dec (.opcode(ir_q[31:26]), .funct(ir_q[5:0]), .kind(kind), .rop(rop));

  assign alu_op   = (kind == K_RALU) ? rop : ALU_ADD;
  assign alu_in_b = (kind == K_RALU) ? b_q : imm_sx;

  mc_alu #(.WIDTH(XW)) i_alu (.op(alu_op), .x(a_q), .y(alu_in_b), .z(alu_y));

  assign rf_we = (step_q == ST_WB) ||
                 (step_q == ST_MEM && (kind == K_RALU || kind == K_ADDI));
  assign rf_wa = (step_q == ST_MEM && kind == K_RALU) ? ir_q[15:11] : ir_q[20:16];
  assign rf_wd = (step_q == ST_WB) ? mdr_q : alu_q;

  mc_regfile #(.WIDTH(XW), .COUNT(NREG)) i_rf (
    .clk(clk), .ra1(ir_q[25:21]), .ra2(ir_q[20:16]), .rd1(rs_val), .rd2(rt_val),
    .we(rf_we), .wa(rf_wa), .wd(rf_wd));

  assign dmem_we = (step_q == ST_MEM) && (kind == K_STORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= ST_FETCH;
      pc_q   <= '0;
      npc_q  <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      tgt_q  <= '0;
      alu_q  <= '0;
      mdr_q  <= '0;
    end else begin
      case (step_q)
        ST_FETCH: begin
          ir_q   <= imem_rd;
          npc_q  <= pc_q + 32'd4;
          step_q <= ST_DECODE;
        end
        ST_DECODE: begin
          a_q    <= rs_val;
          b_q    <= rt_val;
          tgt_q  <= npc_q + {imm_sx[XW-3:0], 2'b00};
          step_q <= ST_EXEC;
        end
        ST_EXEC: begin
          alu_q <= alu_y;
          if (kind == K_BRANCH) begin
            pc_q   <= (a_q == b_q) ? tgt_q : npc_q;
            step_q <= ST_FETCH;
          end else begin
            pc_q   <= npc_q;
            step_q <= ST_MEM;
          end
        end
        ST_MEM: begin
          if (kind == K_LOAD) begin
            mdr_q  <= dmem_rd;
            step_q <= ST_WB;
          end else begin
            step_q <= ST_FETCH;
          end
        end
        default: step_q <= ST_FETCH;
      endcase
    end
  end

  assign pc_o     = pc_q;
  assign retire_o = (step_q == ST_WB) ||
                    (step_q == ST_EXEC && kind == K_BRANCH) ||
                    (step_q == ST_MEM && kind != K_LOAD);
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input step_t       step,
  input kind_t       kind,
  input logic [31:0] pc,
  input logic [31:0] npc,
  input logic [31:0] a_reg,
  input logic [4:0]  rs_f,
  input logic        retire
);
  a_r2_npc_follows_pc: assert property (@(posedge clk) disable iff (rst)
    (step == ST_FETCH) |=> (npc == $past(pc) + 32'd4));

  a_r2_pc_at_retire: assert property (@(posedge clk) disable iff (rst)
    (retire && step != ST_EXEC) |-> (pc == npc));

  a_r8_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (step == ST_DECODE && rs_f == 5'd0) |=> (a_reg == 32'd0));

  a_r7_branch_three: assert property (@(posedge clk) disable iff (rst)
    (step == ST_EXEC && kind == K_BRANCH) |=> (step == ST_FETCH));

  a_r5_wb_only_load: assert property (@(posedge clk) disable iff (rst)
    (step == ST_WB) |-> (kind == K_LOAD));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    retire |=> !retire);
endmodule

bind mc_core mc_core_chk i_chk (
  .clk(clk), .rst(rst), .step(step_q), .kind(kind), .pc(pc_q), .npc(npc_q),
  .a_reg(a_q), .rs_f(ir_q[25:21]), .retire(retire_o));

// File: tb/test_mc_core.sv
module test_mc_core;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS = 64;
  localparam int MAW = $clog2(MEM_WORDS);
  localparam logic [31:0] HALT = 32'h1000_FFFF;   // branch r0==r0 to itself
  localparam logic [31:0] MARK = 32'hA5A5_A5A5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [MAW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic imem_ld_we = 1'b0, dmem_ld_we = 1'b0;
  logic [31:0] imem_peek, dmem_peek, pc_o;
  logic retire_o;

  int errors = 0, checks = 0;
  int lens [16];
  logic [31:0] pcs [16];

  mc_core #(.MEM_WORDS(MEM_WORDS)) i_mc_core (
    .clk(clk), .rst(rst), .ld_addr(ld_addr), .ld_data(ld_data),
    .imem_ld_we(imem_ld_we), .dmem_ld_we(dmem_ld_we), .imem_peek(imem_peek),
    .dmem_peek(dmem_peek), .pc_o(pc_o), .retire_o(retire_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [5:0] fn, int rd, int rs, int rt);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rt, int rs, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic put(input bit to_i, input int addr, input logic [31:0] val);
    @(negedge clk);
    ld_addr = addr[MAW-1:0]; ld_data = val;
    imem_ld_we = to_i; dmem_ld_we = !to_i;
    @(negedge clk);
    imem_ld_we = 1'b0; dmem_ld_we = 1'b0;
  endtask

  task automatic clear_all;
    @(negedge clk);
    rst = 1'b1;
    for (int w = 0; w < MEM_WORDS; w++) begin
      ld_addr = w[MAW-1:0];
      @(negedge clk);
      ld_data = HALT; imem_ld_we = 1'b1; dmem_ld_we = 1'b0;
      @(negedge clk);
      ld_data = MARK; imem_ld_we = 1'b0; dmem_ld_we = 1'b1;
      @(negedge clk);
      dmem_ld_we = 1'b0;
    end
  endtask

  task automatic peek_d(input int addr, output logic [31:0] val);
    @(negedge clk);
    ld_addr = addr[MAW-1:0];
    @(negedge clk);
    val = dmem_peek;
  endtask

  // Release reset, record the length of n instructions and the PC after each.
  task automatic run(input int n);
    int k, last, got;
    bit prev, grab, dbl;
    k = 0; last = -1; got = 0; prev = 0; grab = 0; dbl = 0;
    @(negedge clk);
    rst = 1'b0;
    while (got < n && (k - last) < 50) begin
      @(negedge clk);
      k++;
      if (grab) begin pcs[got-1] = pc_o; grab = 0; end
      if (retire_o) begin
        if (prev) dbl = 1;
        lens[got] = k - last;
        last = k;
        got++;
        grab = 1;
      end
      prev = retire_o;
    end
    if (grab) begin
      @(negedge clk);
      pcs[got-1] = pc_o;
    end
    rst = 1'b1;
    check("R10 retire count", got, n);
    check("R10 pulse width one cycle", {31'd0, dbl}, 32'd0);
  endtask

  function automatic logic [31:0] ref_op(logic [5:0] fn, logic [31:0] x, logic [31:0] y);
    case (fn)
      6'h22:   return x - y;
      6'h24:   return x & y;
      6'h25:   return x | y;
      default: return x + y;
    endcase
  endfunction

  initial begin
    logic [31:0] vals [6];
    logic [5:0]  fns [4];
    int          imms [6];
    logic [31:0] got;
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h1234_5678;
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25;
    imms[0] = 0; imms[1] = 1; imms[2] = -1; imms[3] = 32767; imms[4] = -32768; imms[5] = 100;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pc in reset", pc_o, 32'd0);
    check("R1 retire low in reset", {31'd0, retire_o}, 32'd0);

    // R11: loader and peek ports
    put(1'b1, 3, 32'hCAFE_0003);
    put(1'b0, 5, 32'h0BAD_F00D);
    @(negedge clk); ld_addr = 3;
    @(negedge clk); check("R11 imem peek", imem_peek, 32'hCAFE_0003);
    peek_d(5, got); check("R11 dmem peek", got, 32'h0BAD_F00D);

    // R1/R7: first fetch at 0, self-loop with negative offset
    clear_all();
    run(3);
    for (int i = 0; i < 3; i++) begin
      check("R7 backward branch length", lens[i], 3);
      check("R1 R7 self-loop pc", pcs[i], 32'd0);
    end

    // R3/R5/R6/R2: register ALU sweep
    foreach (fns[f]) for (int i = 0; i < 6; i++) for (int j = 0; j < 6; j++) begin
      clear_all();
      put(1'b1, 0, enc_i(6'h23, 1, 0, 0));
      put(1'b1, 1, enc_i(6'h23, 2, 0, 4));
      put(1'b1, 2, enc_r(fns[f], 3, 1, 2));
      put(1'b1, 3, enc_i(6'h2B, 3, 0, 8));
      put(1'b0, 0, vals[i]);
      put(1'b0, 1, vals[j]);
      run(4);
      peek_d(2, got);
      check("R3 alu result", got, ref_op(fns[f], vals[i], vals[j]));
      check("R3 alu length", lens[2], 4);
      check("R5 load length", lens[0], 5);
      check("R6 store length", lens[3], 4);
      check("R2 pc after store", pcs[3], 32'd16);
    end

    // R4: add-immediate sweep
    foreach (imms[m]) for (int i = 2; i < 5; i++) begin
      clear_all();
      put(1'b1, 0, enc_i(6'h23, 1, 0, 0));
      put(1'b1, 1, enc_i(6'h08, 4, 1, imms[m]));
      put(1'b1, 2, enc_i(6'h2B, 4, 0, 8));
      put(1'b0, 0, vals[i]);
      run(3);
      peek_d(2, got);
      check("R4 addi result", got, vals[i] + 32'(imms[m]));
      check("R4 addi length", lens[1], 4);
    end

    // R5/R6: negative and positive address offsets from a base register
    clear_all();
    put(1'b1, 0, enc_i(6'h23, 1, 0, 0));
    put(1'b1, 1, enc_i(6'h23, 5, 1, -4));
    put(1'b1, 2, enc_i(6'h2B, 5, 1, 12));
    put(1'b0, 0, 32'd40);
    put(1'b0, 9, 32'h1357_9BDF);
    run(3);
    peek_d(13, got);
    check("R5 R6 offset load/store", got, 32'h1357_9BDF);

    // R7: forward branch taken / not taken
    for (int p = 0; p < 4; p++) begin
      logic [31:0] x, y;
      bit tk;
      x = (p == 2) ? 32'hFFFF_FFFF : (p == 3) ? 32'h8000_0000 : 32'd5;
      y = (p == 1) ? 32'd6 : (p == 3) ? 32'd0 : x;
      tk = (x == y);
      clear_all();
      put(1'b1, 0, enc_i(6'h23, 1, 0, 0));
      put(1'b1, 1, enc_i(6'h23, 2, 0, 4));
      put(1'b1, 2, enc_i(6'h04, 2, 1, 2));
      put(1'b1, 3, enc_i(6'h08, 6, 0, 7));
      put(1'b1, 4, enc_i(6'h2B, 6, 0, 8));
      put(1'b1, 5, enc_i(6'h08, 7, 0, 9));
      put(1'b1, 6, enc_i(6'h2B, 7, 0, 12));
      put(1'b0, 0, x);
      put(1'b0, 1, y);
      run(tk ? 5 : 7);
      check("R7 branch length", lens[2], 3);
      check("R7 branch next pc", pcs[2], tk ? 32'd20 : 32'd12);
      peek_d(2, got);
      check("R7 skipped path", got, tk ? MARK : 32'd7);
      peek_d(3, got);
      check("R7 join path", got, 32'd9);
    end

    // R8: register zero
    clear_all();
    put(1'b1, 0, enc_i(6'h23, 1, 0, 0));
    put(1'b1, 1, enc_i(6'h08, 0, 1, 5));
    put(1'b1, 2, enc_r(6'h20, 0, 1, 1));
    put(1'b1, 3, enc_i(6'h2B, 0, 0, 8));
    put(1'b1, 4, enc_r(6'h20, 3, 0, 1));
    put(1'b1, 5, enc_i(6'h2B, 3, 0, 12));
    put(1'b0, 0, 32'd77);
    run(6);
    peek_d(2, got);
    check("R8 r0 stays zero", got, 32'd0);
    peek_d(3, got);
    check("R8 r0 reads zero as operand", got, 32'd77);

    // R9: undefined opcode and undefined funct
    clear_all();
    put(1'b1, 0, enc_i(6'h23, 1, 0, 0));
    put(1'b1, 1, enc_i(6'h3F, 1, 1, 8));
    put(1'b1, 2, enc_r(6'h3F, 1, 1, 1));
    put(1'b1, 3, enc_i(6'h2B, 1, 0, 8));
    put(1'b0, 0, 32'h55);
    run(4);
    check("R9 unknown opcode length", lens[1], 4);
    check("R9 unknown funct length", lens[2], 4);
    check("R9 R2 pc after unknown", pcs[1], 32'd8);
    peek_d(2, got);
    check("R9 register unchanged", got, 32'h55);
    peek_d(1, got);
    check("R9 memory unchanged", got, MARK);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule